// File: doc/BRIEF.md
# CPU Debug Register Access Port

This block sits between an external debug host and a processor core. The host makes one register access at a time over a request/acknowledge handshake. It presents a 3-bit address, a write flag and 64-bit write data, and it receives 64-bit read data. Through this port the host can halt the core, step it one instruction at a time, and inspect its next-instruction address, its machine state register and any entry of its register file.

The register file is reached indirectly. The host first writes an index to the index address. The block holds that index on a dedicated output to the core's register-file read port. A later read of the data address returns whatever the core supplies for that index. Halt and step are bits of a control word. Halt is held as a level. Step produces a one-cycle pulse, and only while the core is already halted.

A small handshake state machine orders every access. It has three states. In `HS_IDLE` it waits for a request. The transition *accept* (request seen) moves it to `HS_RESP`. `HS_RESP` lasts one cycle: acknowledge is driven, read data is valid and writes take effect at its closing edge. The transition *respond* always moves it to `HS_HOLD`. `HS_HOLD` waits for the host to drop its request, and the transition *release* (request low) returns it to `HS_IDLE`.

Top module: `dbg_port`

## Requirements
- R1: A request seen in `HS_IDLE` is acknowledged in the following cycle. Acknowledge is high for exactly one cycle. No further acknowledge is given while the request stays high after that cycle.
- R2: After reset, acknowledge, halt and step are low, the register index output is zero and read data is zero.
- R3: A write to address 0 sets the halt output to bit 0 of the write data. The new level appears in the cycle after the acknowledge and holds until the next write to address 0.
- R4: A write to address 0 with bit 3 set gives a step pulse exactly one cycle long in the cycle after the acknowledge, but only if halt was high before that write. Otherwise no pulse is given.
- R5: A read of address 2 returns the core's next-instruction address input during the acknowledge cycle.
- R6: A read of address 3 returns the core's machine state register input during the acknowledge cycle.
- R7: A write to address 4 loads the register index output from the low bits of the write data. The new index appears in the cycle after the acknowledge. Indices 0 to 31 select the general-purpose registers.
- R8: A read of address 5 returns the register-file data input, which the core supplies for the index last written.
- R9: Reads of addresses 1, 6 and 7 return zero. A read of address 0 returns the current halt level in bit 0 and zero in every other bit.
- R10: Writes to addresses 1, 2, 3, 5, 6 and 7 are acknowledged but change neither the halt level nor the register index.
- R11: Read data is zero in every cycle other than the acknowledge cycle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host request, held until acknowledged |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Debug register address |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, valid with acknowledge |
| ack | output | 1 | One-cycle acknowledge |
| core_stop | output | 1 | Halt request level to the core |
| core_step | output | 1 | One-cycle single-step pulse to the core |
| core_nia | input | 64 | Core next-instruction address |
| core_msr | input | 64 | Core machine state register |
| rf_index | output | 6 | Register-file read index |
| rf_data | input | 64 | Register-file read data for `rf_index` |

## Verification
The release from halt and the step pulse can land in the same cycle. A control write of 0x8 while halted clears halt and also fires a step, because the step is qualified by the halt level held before the write. The bench provokes this case on purpose and samples both outputs in the cycle after the acknowledge. It expects step high and halt low together. It also checks that a step written while the core runs produces no pulse at all.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] DA_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] DA_NIA  = 3'd2;
    localparam logic [ADDR_W-1:0] DA_MSR  = 3'd3;
    localparam logic [ADDR_W-1:0] DA_IDX  = 3'd4;
    localparam logic [ADDR_W-1:0] DA_REG  = 3'd5;

    localparam int CTRL_HALT_BIT = 0;
    localparam int CTRL_STEP_BIT = 3;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_RESP = 2'd1,
        HS_HOLD = 2'd2
    } hs_state_e;

endpackage

// File: rtl/dbg_handshake.sv
module dbg_handshake
    import dbg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic ack,
    output logic commit
);

    hs_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        ack     = 1'b0;
        commit  = 1'b0;
        unique case (state_q)
            HS_IDLE: begin
                if (req) state_d = HS_RESP;      // accept
            end
            HS_RESP: begin
                ack     = 1'b1;
                commit  = 1'b1;
                state_d = HS_HOLD;               // respond
            end
            HS_HOLD: begin
                if (!req) state_d = HS_IDLE;     // release
            end
            default: begin
                state_d = HS_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/dbg_ctrl.sv
module dbg_ctrl
    import dbg_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic          halt,
    output logic          step
);

    logic halt_q, step_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
            step_q <= 1'b0;
        end else begin
            // step qualified by the halt level before this write
            step_q <= wr_en & wdata[CTRL_STEP_BIT] & halt_q;
            if (wr_en) begin
                halt_q <= wdata[CTRL_HALT_BIT];
            end
        end
    end

    assign halt = halt_q;
    assign step = step_q;

endmodule

// File: rtl/dbg_index.sv
module dbg_index #(
    parameter int DW   = 64,
    parameter int IDXW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DW-1:0]   wdata,
    output logic [IDXW-1:0] index
);

    logic [IDXW-1:0] index_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= '0;
        end else if (wr_en) begin
            index_q <= wdata[IDXW-1:0];
        end
    end

    assign index = index_q;

endmodule

// File: rtl/dbg_rdmux.sv
module dbg_rdmux
    import dbg_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              halt,
    input  logic [DW-1:0]     nia,
    input  logic [DW-1:0]     msr,
    input  logic [DW-1:0]     rf_data,
    output logic [DW-1:0]     rdata
);

    logic [DW-1:0] sel;

    always_comb begin
        sel = '0;
        unique case (addr)
            DA_CTRL: sel[CTRL_HALT_BIT] = halt;
            DA_NIA:  sel = nia;
            DA_MSR:  sel = msr;
            DA_REG:  sel = rf_data;
            default: sel = '0;
        endcase
    end

    assign rdata = rd_en ? sel : '0;

endmodule

// File: rtl/dbg_port.sv
module dbg_port
    import dbg_pkg::*;
#(
    parameter int DW   = 64,
    parameter int IDXW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              ack,
    output logic              core_stop,
    output logic              core_step,
    input  logic [DW-1:0]     core_nia,
    input  logic [DW-1:0]     core_msr,
    output logic [IDXW-1:0]   rf_index,
    input  logic [DW-1:0]     rf_data
);

    logic commit;
    logic ctrl_we, idx_we, rd_en;

    dbg_handshake u_hs (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .ack    (ack),
        .commit (commit)
    );

    assign ctrl_we = commit & wr & (addr == DA_CTRL);
    assign idx_we  = commit & wr & (addr == DA_IDX);
    assign rd_en   = commit & ~wr;

    dbg_ctrl #(.DW(DW)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ctrl_we),
        .wdata (wdata),
        .halt  (core_stop),
        .step  (core_step)
    );

    dbg_index #(.DW(DW), .IDXW(IDXW)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (idx_we),
        .wdata (wdata),
        .index (rf_index)
    );

    dbg_rdmux #(.DW(DW)) u_rd (
        .addr    (addr),
        .rd_en   (rd_en),
        .halt    (core_stop),
        .nia     (core_nia),
        .msr     (core_msr),
        .rf_data (rf_data),
        .rdata   (rdata)
    );

endmodule

// File: rtl/dbg_port_chk.sv
module dbg_port_chk #(
    parameter int DW   = 64,
    parameter int IDXW = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req,
    input logic            wr,
    input logic [2:0]      addr,
    input logic [DW-1:0]   wdata,
    input logic [DW-1:0]   rdata,
    input logic            ack,
    input logic            core_stop,
    input logic            core_step,
    input logic [DW-1:0]   core_nia,
    input logic [DW-1:0]   core_msr,
    input logic [IDXW-1:0] rf_index
);

    a_r1_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    a_r1_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(req));

    a_r1_no_reack_while_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ack) && req) |=> !ack);

    a_r3_halt_moves_on_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(core_stop) |-> $past(ack && wr && addr == 3'd0));

    a_r4_step_single: assert property (@(posedge clk) disable iff (!rst_n)
        core_step |=> !core_step);

    a_r4_step_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        core_step |-> $past(ack && wr && addr == 3'd0 && wdata[3] && core_stop));

    a_r5_nia_read: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wr && addr == 3'd2) |-> rdata == core_nia);

    a_r6_msr_read: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wr && addr == 3'd3) |-> rdata == core_msr);

    a_r7_index_moves_on_idx_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rf_index) |-> $past(ack && wr && addr == 3'd4));

    a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wr && (addr == 3'd1 || addr == 3'd6 || addr == 3'd7)) |-> rdata == '0);

    a_r11_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack || wr) |-> rdata == '0);

endmodule

bind dbg_port dbg_port_chk #(.DW(DW), .IDXW(IDXW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .wr        (wr),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .ack       (ack),
    .core_stop (core_stop),
    .core_step (core_step),
    .core_nia  (core_nia),
    .core_msr  (core_msr),
    .rf_index  (rf_index)
);

// File: tb/dbg_port_tb.sv
module dbg_port_tb;

    localparam int DW   = 64;
    localparam int IDXW = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req = 1'b0;
    logic            wr = 1'b0;
    logic [2:0]      addr = '0;
    logic [DW-1:0]   wdata = '0;
    logic [DW-1:0]   rdata;
    logic            ack;
    logic            core_stop, core_step;
    logic [DW-1:0]   core_nia = 64'h0000_0000_0000_1000;
    logic [DW-1:0]   core_msr = 64'h8000_0000_0000_0001;
    logic [IDXW-1:0] rf_index;
    logic [DW-1:0]   rf_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #2.5 clk = ~clk;

    // bench model of the register file
    assign rf_data = {32'hC0DE_0000, {(32-IDXW){1'b0}}, rf_index};

    dbg_port #(.DW(DW), .IDXW(IDXW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ack(ack),
        .core_stop(core_stop), .core_step(core_step),
        .core_nia(core_nia), .core_msr(core_msr),
        .rf_index(rf_index), .rf_data(rf_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares read data against the scoreboard
    always @(negedge clk) begin
        if (rst_n && ack && !wr) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5/R6/R8/R9 unexpected read ack", rdata, '0);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rdata === e, t, rdata, e);
            end
        end
        if (rst_n && !(ack && !wr)) begin
            chk(rdata === '0, "R11 rdata idle", rdata, '0);
        end
    end

    logic step_seen, stop_after;

    task automatic xact(input logic w, input logic [2:0] a, input logic [DW-1:0] d,
                        input int extra_hold);
        int n;
        @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = d;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ack && n < 50);
        chk(ack === 1'b1 && n == 1, "R1 ack one cycle after request", {63'd0, ack}, 64'd1);
        @(negedge clk);
        chk(ack === 1'b0, "R1 ack single cycle", {63'd0, ack}, 64'd0);
        step_seen  = core_step;
        stop_after = core_stop;
        for (int i = 0; i < extra_hold; i++) begin
            @(negedge clk);
            chk(ack === 1'b0, "R1 no re-ack while request held", {63'd0, ack}, 64'd0);
        end
        req = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, input logic [DW-1:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        xact(1'b0, a, '0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state (still in reset)
        chk(ack === 1'b0, "R2 ack at reset", {63'd0, ack}, 64'd0);
        chk(core_stop === 1'b0, "R2 halt at reset", {63'd0, core_stop}, 64'd0);
        chk(core_step === 1'b0, "R2 step at reset", {63'd0, core_step}, 64'd0);
        chk(rf_index === '0, "R2 index at reset", 64'(rf_index), 64'd0);
        chk(rdata === '0, "R2 rdata at reset", rdata, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 / R6 reads
        rd(3'd2, 64'h0000_0000_0000_1000, "R5 nia read");
        rd(3'd3, 64'h8000_0000_0000_0001, "R6 msr read");
        core_nia = 64'hDEAD_BEEF_0000_2004;
        core_msr = 64'h0000_0000_0000_A000;
        rd(3'd2, 64'hDEAD_BEEF_0000_2004, "R5 nia read changed");
        rd(3'd3, 64'h0000_0000_0000_A000, "R6 msr read changed");

        // R9 control read and unused addresses
        rd(3'd0, 64'd0, "R9 ctrl read running");
        rd(3'd1, 64'd0, "R9 addr1 zero");
        rd(3'd6, 64'd0, "R9 addr6 zero");
        rd(3'd7, 64'd0, "R9 addr7 zero");

        // R4 step while running: no pulse
        xact(1'b1, 3'd0, 64'h8, 0);
        chk(step_seen === 1'b0, "R4 no step while running", {63'd0, step_seen}, 64'd0);
        chk(stop_after === 1'b0, "R3 halt stays low", {63'd0, stop_after}, 64'd0);

        // R3 halt
        xact(1'b1, 3'd0, 64'h1, 0);
        chk(stop_after === 1'b1, "R3 halt set", {63'd0, stop_after}, 64'd1);
        chk(step_seen === 1'b0, "R4 no step on plain halt", {63'd0, step_seen}, 64'd0);
        rd(3'd0, 64'd1, "R9 ctrl read halted");

        // R4 step while halted, halt kept
        xact(1'b1, 3'd0, 64'h9, 0);
        chk(step_seen === 1'b1, "R4 step pulse while halted", {63'd0, step_seen}, 64'd1);
        chk(stop_after === 1'b1, "R3 halt kept with step", {63'd0, stop_after}, 64'd1);
        chk(core_step === 1'b0, "R4 step one cycle", {63'd0, core_step}, 64'd0);

        // R7 / R8 index and register read
        xact(1'b1, 3'd4, 64'd7, 0);
        chk(rf_index === 6'd7, "R7 index 7", 64'(rf_index), 64'd7);
        rd(3'd5, {32'hC0DE_0000, 32'd7}, "R8 reg 7 read");
        xact(1'b1, 3'd4, 64'hFFFF_FFFF_FFFF_FF1F, 0);
        chk(rf_index === 6'd31, "R7 index 31 low bits", 64'(rf_index), 64'd31);
        rd(3'd5, {32'hC0DE_0000, 32'd31}, "R8 reg 31 read");

        // R10 writes to read-only / unused addresses ignored
        xact(1'b1, 3'd2, 64'h0, 0);
        xact(1'b1, 3'd3, 64'h0, 0);
        xact(1'b1, 3'd5, 64'd3, 0);
        xact(1'b1, 3'd1, 64'h0, 0);
        xact(1'b1, 3'd6, 64'h0, 0);
        xact(1'b1, 3'd7, 64'd2, 0);
        chk(core_stop === 1'b1, "R10 halt untouched", {63'd0, core_stop}, 64'd1);
        chk(rf_index === 6'd31, "R10 index untouched", 64'(rf_index), 64'd31);

        // R1 request held past acknowledge
        exp_q.push_back({32'hC0DE_0000, 32'd31});
        tag_q.push_back("R8 read with long hold");
        xact(1'b0, 3'd5, '0, 4);

        // R3 + R4 same cycle: release halt and step together
        xact(1'b1, 3'd0, 64'h8, 0);
        chk(step_seen === 1'b1, "R4 step on release write", {63'd0, step_seen}, 64'd1);
        chk(stop_after === 1'b0, "R3 halt cleared same cycle", {63'd0, stop_after}, 64'd0);

        // R7 index back to zero
        xact(1'b1, 3'd4, 64'd0, 0);
        chk(rf_index === 6'd0, "R7 index 0", 64'(rf_index), 64'd0);
        rd(3'd5, {32'hC0DE_0000, 32'd0}, "R8 reg 0 read");

        chk(exp_q.size() == 0, "R1 all reads acknowledged", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) chk(1'b0, "R1 watchdog expired", 64'd0, 64'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule